// File: doc/BRIEF.md
# Interrupt Acknowledge and Deactivation Tracker

This block holds the per-source interrupt state of a small interrupt controller CPU interface. Each source can be inactive, pending, active, or active-and-pending. Level interrupt lines feed the pending state. Software-style strobes drive the lifecycle of a source: acknowledge, end-of-interrupt, deactivate, and direct set-active and clear-active writes. Each source also has a running flag. It marks a source that has been acknowledged but has not yet had its priority dropped.

A split-mode control chooses how completion works. With split mode off, end-of-interrupt drops the priority and deactivates the source at once. With split mode on, end-of-interrupt only drops the priority, and the source stays active until a separate deactivate write arrives. No priority arbitration is done here. An acknowledge picks the lowest-numbered eligible source. A source is eligible when it is pending and not active.

Top module: `irqtrk`

## Requirements
- R1: After reset, the pending, active and running vectors are all zero, and the acknowledged ID reads 1023.
- R2: The pending bit of every source equals its interrupt line as sampled at the previous clock edge, whatever the source's active state.
- R3: An acknowledge with at least one eligible source (pending and not active, using the state before that edge) selects the lowest-numbered one. From the next cycle, the acknowledged ID holds its number and its active and running bits are set. Its pending bit stays 1 (active-and-pending) if the line is still high, and drops to 0 if the line was low.
- R4: A source that is active and pending is not eligible, so an acknowledge passes over it to the next eligible source.
- R5: An acknowledge with no eligible source sets the acknowledged ID to the spurious value 1023 and changes no active or running bit.
- R6: With split mode off, an end-of-interrupt for an in-range ID clears both the running and the active bit of that source.
- R7: With split mode on, an end-of-interrupt for an in-range ID clears only the running bit; the active bit stays set.
- R8: With split mode on, a deactivate write takes the source ID from bits [9:0] of the 32-bit written value, ignores the upper bits, and clears that source's active bit.
- R9: A deactivate write while split mode is off changes no state.
- R10: An end-of-interrupt or deactivate whose ID is at or above the number of sources changes no state.
- R11: A set-active write sets the active bits selected by its mask, and a clear-active write clears them. When both arrive in the same cycle, the set wins for overlapping bits. Neither changes the running bits.
- R12: The acknowledged ID holds its value in every cycle without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| split_en | input | 1 | 1: end-of-interrupt only drops priority; deactivate is a separate write |
| irq_lines | input | NUM_SRC | Level interrupt inputs |
| ack_req | input | 1 | Acknowledge strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_id | input | ID_W | Source ID for end-of-interrupt |
| deact_req | input | 1 | Deactivate strobe |
| deact_wdata | input | WDATA_W | Deactivate write value; ID in the low ID_W bits |
| set_act_req | input | 1 | Set-active strobe |
| set_act_mask | input | NUM_SRC | Bits to make active |
| clr_act_req | input | 1 | Clear-active strobe |
| clr_act_mask | input | NUM_SRC | Bits to make inactive |
| pending | output | NUM_SRC | Pending state per source |
| active | output | NUM_SRC | Active state per source |
| running | output | NUM_SRC | Acknowledged and not yet priority-dropped |
| ack_id | output | ID_W | Last acknowledged ID, 1023 when spurious |

## Verification
The bench targets these corner cases:

- **Re-acknowledge of an active-and-pending source.** A tracker that only tests the pending bit would hand the same source out twice. The bench would see a repeated ID instead of the next source or 1023.
- **Split mode.** An end-of-interrupt that always deactivates would clear the active bit too early. A deactivate honoured with split mode off would clear it when it should stay set.
- **Out-of-range IDs.** The bench uses 1023 and values from 32 upward. A decoder that wraps or truncates them would clear a real source.
- **Upper bits of the deactivate value.** Set upper bits must not change which source is cleared.
- **Same-cycle set-active and clear-active.** The bench overlaps the two masks to fix which one wins.

// File: rtl/irqtrk_pkg.sv
package irqtrk_pkg;
    localparam int unsigned SPURIOUS_ID = 1023;
endpackage

// File: rtl/irqtrk_id_dec.sv
module irqtrk_id_dec #(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = 10
) (
    input  logic               en,
    input  logic [ID_W-1:0]    id,
    output logic [NUM_SRC-1:0] sel
);
    logic in_range;
    assign in_range = en && (32'(id) < NUM_SRC);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
        assign sel[i] = in_range && (id == ID_W'(i));
    end
endmodule

// File: rtl/irqtrk_pick.sv
module irqtrk_pick #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irqtrk.sv
module irqtrk
    import irqtrk_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = 10,
    parameter int WDATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               split_en,
    input  logic [NUM_SRC-1:0] irq_lines,
    input  logic               ack_req,
    input  logic               eoi_req,
    input  logic [ID_W-1:0]    eoi_id,
    input  logic               deact_req,
    input  logic [WDATA_W-1:0] deact_wdata,
    input  logic               set_act_req,
    input  logic [NUM_SRC-1:0] set_act_mask,
    input  logic               clr_act_req,
    input  logic [NUM_SRC-1:0] clr_act_mask,
    output logic [NUM_SRC-1:0] pending,
    output logic [NUM_SRC-1:0] active,
    output logic [NUM_SRC-1:0] running,
    output logic [ID_W-1:0]    ack_id
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [ID_W-1:0] SPUR = ID_W'(SPURIOUS_ID);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] act;
        logic [NUM_SRC-1:0] run;
        logic [ID_W-1:0]    ack_id;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic [NUM_SRC-1:0] eoi_sel;
    logic [NUM_SRC-1:0] deact_sel;
    logic [NUM_SRC-1:0] eligible;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;

    irqtrk_id_dec #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_eoi_dec (
        .en  (eoi_req),
        .id  (eoi_id),
        .sel (eoi_sel)
    );

    irqtrk_id_dec #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_deact_dec (
        .en  (deact_req && split_en),
        .id  (deact_wdata[ID_W-1:0]),
        .sel (deact_sel)
    );

    assign eligible = st_q.pend & ~st_q.act;

    irqtrk_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req (eligible),
        .any (pick_any),
        .idx (pick_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = irq_lines;
        if (clr_act_req) st_d.act = st_d.act & ~clr_act_mask;
        if (set_act_req) st_d.act = st_d.act | set_act_mask;
        st_d.run = st_d.run & ~eoi_sel;
        if (!split_en) st_d.act = st_d.act & ~eoi_sel;
        st_d.act = st_d.act & ~deact_sel;
        if (ack_req) begin
            if (pick_any) begin
                st_d.act[pick_idx] = 1'b1;
                st_d.run[pick_idx] = 1'b1;
                st_d.ack_id        = ID_W'(pick_idx);
            end else begin
                st_d.ack_id = SPUR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend   <= '0;
            st_q.act    <= '0;
            st_q.run    <= '0;
            st_q.ack_id <= SPUR;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pend;
    assign active  = st_q.act;
    assign running = st_q.run;
    assign ack_id  = st_q.ack_id;
endmodule

// File: rtl/irqtrk_chk.sv
module irqtrk_chk #(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = 10,
    parameter int WDATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               split_en,
    input logic [NUM_SRC-1:0] irq_lines,
    input logic               ack_req,
    input logic               eoi_req,
    input logic [ID_W-1:0]    eoi_id,
    input logic               deact_req,
    input logic [WDATA_W-1:0] deact_wdata,
    input logic               set_act_req,
    input logic               clr_act_req,
    input logic [NUM_SRC-1:0] pending,
    input logic [NUM_SRC-1:0] active,
    input logic [NUM_SRC-1:0] running,
    input logic [ID_W-1:0]    ack_id
);
    logic only_ack, only_eoi, only_deact, no_op;
    assign no_op      = !ack_req && !eoi_req && !deact_req && !set_act_req && !clr_act_req;
    assign only_ack   = ack_req && !eoi_req && !deact_req && !set_act_req && !clr_act_req;
    assign only_eoi   = eoi_req && !ack_req && !deact_req && !set_act_req && !clr_act_req;
    assign only_deact = deact_req && !ack_req && !eoi_req && !set_act_req && !clr_act_req;

    // R2
    pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pending == $past(irq_lines));

    // R5
    spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        only_ack && ((pending & ~active) == '0) |=>
            (ack_id == ID_W'(1023)) && (active == $past(active)) && (running == $past(running)));

    // R3
    ack_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req && ((pending & ~active) != '0) |=>
            (32'(ack_id) < NUM_SRC) && ((active >> ack_id) & 1) == 1 && ((running >> ack_id) & 1) == 1);

    // R7
    split_eoi_keeps_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        only_eoi && split_en |=> active == $past(active));

    // R9
    deact_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        only_deact && !split_en |=> active == $past(active) && running == $past(running));

    // R10
    eoi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        only_eoi && (32'(eoi_id) >= NUM_SRC) |=> active == $past(active) && running == $past(running));

    // R12
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_op |=> $stable(ack_id));
endmodule

bind irqtrk irqtrk_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .WDATA_W(WDATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .split_en    (split_en),
    .irq_lines   (irq_lines),
    .ack_req     (ack_req),
    .eoi_req     (eoi_req),
    .eoi_id      (eoi_id),
    .deact_req   (deact_req),
    .deact_wdata (deact_wdata),
    .set_act_req (set_act_req),
    .clr_act_req (clr_act_req),
    .pending     (pending),
    .active      (active),
    .running     (running),
    .ack_id      (ack_id)
);

// File: tb/irqtrk_tb.sv
module irqtrk_tb;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          split_en = 1'b0;
    logic [N-1:0]  irq_lines = '0;
    logic          ack_req = 1'b0;
    logic          eoi_req = 1'b0;
    logic [9:0]    eoi_id = '0;
    logic          deact_req = 1'b0;
    logic [31:0]   deact_wdata = '0;
    logic          set_act_req = 1'b0;
    logic [N-1:0]  set_act_mask = '0;
    logic          clr_act_req = 1'b0;
    logic [N-1:0]  clr_act_mask = '0;
    logic [N-1:0]  pending, active, running;
    logic [9:0]    ack_id;

    always #2 clk = ~clk;

    irqtrk #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .split_en(split_en), .irq_lines(irq_lines),
        .ack_req(ack_req), .eoi_req(eoi_req), .eoi_id(eoi_id),
        .deact_req(deact_req), .deact_wdata(deact_wdata),
        .set_act_req(set_act_req), .set_act_mask(set_act_mask),
        .clr_act_req(clr_act_req), .clr_act_mask(clr_act_mask),
        .pending(pending), .active(active), .running(running), .ack_id(ack_id)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [N-1:0] m_pend = '0, m_act = '0, m_run = '0;
    logic [9:0]   m_ack = 10'd1023;

    task automatic check(string tag, string what, logic [63:0] act_v, logic [63:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act_v, exp_v);
        end
    endtask

    task automatic compare_all(string tag);
        check("R2", "pending", 64'(pending), 64'(m_pend));
        check(tag, "active", 64'(active), 64'(m_act));
        check(tag, "running", 64'(running), 64'(m_run));
        check(tag, "ack_id", 64'(ack_id), 64'(m_ack));
    endtask

    // Inputs are set at a negedge; this advances one edge and compares.
    task automatic step(string tag);
        logic [N-1:0] n_pend, n_act, n_run;
        logic [9:0]   n_ack;
        int           d;
        bit           found;
        n_pend = irq_lines;
        n_act  = m_act;
        n_run  = m_run;
        n_ack  = m_ack;
        if (clr_act_req) n_act &= ~clr_act_mask;
        if (set_act_req) n_act |= set_act_mask;
        if (eoi_req && eoi_id < N) begin
            n_run[eoi_id] = 1'b0;
            if (!split_en) n_act[eoi_id] = 1'b0;
        end
        d = int'(deact_wdata[9:0]);
        if (deact_req && split_en && d < N) n_act[d] = 1'b0;
        if (ack_req) begin
            found = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (!found && m_pend[i] && !m_act[i]) begin
                    found = 1'b1;
                    n_act[i] = 1'b1;
                    n_run[i] = 1'b1;
                    n_ack = 10'(i);
                end
            end
            if (!found) n_ack = 10'd1023;
        end
        @(posedge clk);
        @(negedge clk);
        m_pend = n_pend; m_act = n_act; m_run = n_run; m_ack = n_ack;
        compare_all(tag);
        ack_req = 0; eoi_req = 0; deact_req = 0; set_act_req = 0; clr_act_req = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "pending", 64'(pending), 64'd0);
        check("R1", "active", 64'(active), 64'd0);
        check("R1", "running", 64'(running), 64'd0);
        check("R1", "ack_id", 64'(ack_id), 64'd1023);
        rst_n = 1'b1;

        // R2 lines appear on pending
        irq_lines[3] = 1; irq_lines[7] = 1;
        step("R2");
        // R3 ack picks 3, line still high -> active-and-pending
        ack_req = 1; step("R3");
        check("R3", "pend3 kept", 64'(pending[3]), 64'd1);
        // R4 active-and-pending 3 skipped, 7 chosen; line 3 drops
        irq_lines[3] = 0; ack_req = 1; step("R4");
        check("R4", "ack_id", 64'(ack_id), 64'd7);
        // R3 ack on low line: 9 pulses, ack when line is low
        irq_lines[9] = 1; step("R2");
        irq_lines[9] = 0; ack_req = 1; step("R3");
        check("R3", "pend9 cleared", 64'(pending[9]), 64'd0);
        // R5 nothing eligible
        ack_req = 1; step("R5");
        check("R5", "spurious", 64'(ack_id), 64'd1023);
        // R12 hold
        step("R12"); step("R12");
        // R6 non-split eoi
        eoi_id = 10'd3; eoi_req = 1; step("R6");
        // R7 split eoi
        split_en = 1; eoi_id = 10'd7; eoi_req = 1; step("R7");
        check("R7", "act7 kept", 64'(active[7]), 64'd1);
        // R8 deactivate with upper garbage
        deact_wdata = 32'hFFFF_FC07; deact_req = 1; step("R8");
        check("R8", "act7 cleared", 64'(active[7]), 64'd0);
        // R11 set-active
        set_act_mask = 32'h0000_0120; set_act_req = 1; step("R11");
        // R9 deactivate with split off
        split_en = 0; deact_wdata = 32'd5; deact_req = 1; step("R9");
        check("R9", "act5 kept", 64'(active[5]), 64'd1);
        // R10 out-of-range ids
        eoi_id = 10'd40; eoi_req = 1; step("R10");
        split_en = 1; deact_wdata = 32'h0000_03FF; deact_req = 1; step("R10");
        eoi_id = 10'd32; eoi_req = 1; step("R10");
        // R11 set and clear together, set wins
        set_act_mask = 32'h0000_0030; clr_act_mask = 32'h0000_0130;
        set_act_req = 1; clr_act_req = 1; step("R11");
        check("R11", "act bits", 64'(active & 32'h130), 64'h30);

        // Constrained random
        for (int n = 0; n < 4000; n++) begin
            int op;
            string tag;
            for (int b = 0; b < N; b++)
                if ($urandom_range(0, 15) == 0) irq_lines[b] = ~irq_lines[b];
            if ($urandom_range(0, 31) == 0) split_en = ~split_en;
            op = $urandom_range(0, 6);
            tag = "R2";
            case (op)
                0, 1: begin ack_req = 1; tag = "R3"; end
                2: begin
                    eoi_req = 1;
                    eoi_id = ($urandom_range(0, 3) == 0) ? 10'($urandom_range(32, 1023))
                                                         : 10'($urandom_range(0, 31));
                    tag = (eoi_id >= N) ? "R10" : (split_en ? "R7" : "R6");
                end
                3: begin
                    deact_req = 1;
                    deact_wdata = {$urandom_range(0, 65535), 6'd0,
                                   ($urandom_range(0, 3) == 0) ? 10'($urandom_range(32, 1023))
                                                               : 10'($urandom_range(0, 31))};
                    tag = !split_en ? "R9" : ((deact_wdata[9:0] >= N) ? "R10" : "R8");
                end
                4: begin set_act_req = 1; set_act_mask = $urandom & $urandom; tag = "R11"; end
                5: begin clr_act_req = 1; clr_act_mask = $urandom | $urandom; tag = "R11"; end
                default: tag = "R12";
            endcase
            step(tag);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule